// File: doc/BRIEF.md
# Sample Capture Trigger Controller

This block decides which samples of a digitizer's stream are written to sample memory. It sees one sample word per clock, an asynchronous trigger line and a set of static configuration inputs. It drives a single write port: an enable, a word address and the data. In dual-channel operation the incoming stream is already interleaved, one channel per word, and the block stores words in arrival order.

There are three capture styles. In start-on-trigger mode the trigger opens a single fill of a region. In history mode the block records into a ring from the moment it is armed. A trigger then closes the capture, so samples from before the event are kept. In segmented mode each trigger fills one fixed-size slice of memory. The block then waits for the next trigger, until a programmed number of slices has been written. An optional delay between trigger and storage applies to the start-on-trigger and segmented styles. Completion is reported on a sticky done flag, which software clears by arming again.

Top module: `acq_trig_ctrl`

## Requirements
- R1: The trigger line goes through a two-flop synchroniser and an edge register, and only a low-to-high change counts. With zero delay, storage begins with the sample word presented three clocks after `trig_i` goes high. A trigger held high counts once.
- R2: In mode 0 (mode 3 behaves the same), an accepted trigger writes exactly `len_i` words to consecutive addresses `base_i` to `base_i+len_i-1`, then sets done.
- R3: A nonzero `delay_i` of D (at most 65536) postpones the first stored word by exactly D clocks relative to the zero-delay case.
- R4: In mode 1, writing starts on the clock after arming. Every clock writes one word, cycling through addresses `base_i` to `base_i+len_i-1` and wrapping back to `base_i`.
- R5: In mode 1, a trigger edge is dropped until at least P words have been written since arming, and `armed_o` is high only after that. An accepted trigger latches the address written in its detect clock (the word presented two clocks after `trig_i` rose) on `trig_addr_o`. Exactly `len_i-P` further words follow, then done.
- R6: The history depth P in words is min(`pre_i`, 8192) with `dual_i` low. With `dual_i` high it is 2*min(`pre_i`, 4096), because `pre_i` counts samples per channel.
- R7: In mode 2, segment k (from 0) fills `len_i` words starting at `base_i + k*len_i`. Each segment starts on its own trigger, and done is set after `seg_num_i` segments. A count of 0 acts as 1.
- R8: A trigger edge that arrives while idle, during a delay or during a fill has no effect. `armed_o` is low at those times.
- R9: Done is low after reset. Once set it holds until `arm_i` is pulsed while idle, which clears it. Arming is accepted only while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Arm pulse; clears done |
| mode_i | input | 2 | 0 start-on-trigger, 1 history, 2 segmented |
| dual_i | input | 1 | Two interleaved channels |
| base_i | input | 27 | First word address of the region |
| len_i | input | 28 | Region or segment length in words |
| pre_i | input | 14 | History depth in samples per channel |
| delay_i | input | 17 | Trigger-to-storage delay in clocks |
| seg_num_i | input | 8 | Segments to capture |
| trig_i | input | 1 | Asynchronous trigger |
| sample_i | input | 16 | Sample word stream |
| wr_en_o | output | 1 | Memory write enable |
| wr_addr_o | output | 27 | Memory word address |
| wr_data_o | output | 16 | Memory write data |
| trig_addr_o | output | 27 | Address of the trigger word in history mode |
| armed_o | output | 1 | A trigger edge would be accepted now |
| done_o | output | 1 | Capture complete |

## Verification
The bench feeds a counting sample stream, so every stored word identifies the clock it came from. That makes the latency from trigger to first word, and any off-by-one in the delay counter, visible as a wrong data value. It fires triggers too early in history mode, during a delay and in the middle of a segment fill. A design that honoured any of these would start a capture early or shift a segment's contents, and the ring position check would catch a trigger accepted before the history was full. The history depth is measured from arming to `armed_o` at both clamp limits and in both channel modes. A wrong clamp or a missing doubling changes that count directly. The longest delay, 65536 clocks, is run in full to catch a counter that is one bit too narrow.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [1:0] {
    MODE_POST = 2'd0,
    MODE_PRE  = 2'd1,
    MODE_SEG  = 2'd2,
    MODE_RSV  = 2'd3
  } acq_mode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT,
    S_DLY,
    S_FILL,
    S_RING,
    S_TAIL
  } acq_state_e;
endpackage

// File: rtl/acq_trig_sync.sv
module acq_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], trig_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  AST_RISE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o) else $error("rise held"); // R1
endmodule

// File: rtl/acq_delay_timer.sv
module acq_delay_timer #(
  parameter int W = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] len_i,
  output logic         exp_o
);
  logic [W-1:0] cnt_q;
  logic         run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= len_i - W'(1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - W'(1);
    end
  end

  assign exp_o = run_q && (cnt_q == '0);

  AST_DLY_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt_q != '0 && !start_i) |=> (run_q && cnt_q == $past(cnt_q) - W'(1)))
    else $error("delay count skipped"); // R3
endmodule

// File: rtl/acq_pre_depth.sv
module acq_pre_depth #(
  parameter int PRE_W   = 14,
  parameter int PRE_MAX = 8192
) (
  input  logic             dual_i,
  input  logic [PRE_W-1:0] pre_i,
  output logic [PRE_W:0]   words_o
);
  localparam int PW = PRE_W + 1;
  localparam logic [PW-1:0] LIM_ONE = PW'(PRE_MAX);
  localparam logic [PW-1:0] LIM_TWO = PW'(PRE_MAX / 2);

  logic [PW-1:0] lim, req, eff;

  always_comb begin
    lim     = dual_i ? LIM_TWO : LIM_ONE;
    req     = PW'(pre_i);
    eff     = (req > lim) ? lim : req;
    words_o = dual_i ? (eff << 1) : eff;
    if (!$isunknown(words_o))
      AST_PRE_CAP: assert (words_o <= LIM_ONE) else $error("depth over cap"); // R6
  end
endmodule

// File: rtl/acq_trig_ctrl.sv
module acq_trig_ctrl
  import acq_pkg::*;
#(
  parameter int ADDR_W      = 27,
  parameter int LEN_W       = ADDR_W + 1,
  parameter int DATA_W      = 16,
  parameter int PRE_W       = 14,
  parameter int PRE_MAX     = 8192,
  parameter int DLY_W       = 17,
  parameter int SEG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic [1:0]        mode_i,
  input  logic              dual_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [PRE_W-1:0]  pre_i,
  input  logic [DLY_W-1:0]  delay_i,
  input  logic [SEG_W-1:0]  seg_num_i,
  input  logic              trig_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [ADDR_W-1:0] trig_addr_o,
  output logic              armed_o,
  output logic              done_o
);
  localparam int SC_W = SEG_W + 1;

  acq_state_e        state_q;
  acq_mode_e         mode;
  logic [ADDR_W-1:0] seg_base_q, trig_addr_q;
  logic [LEN_W-1:0]  off_q, rem_q, tail_len, off_nxt;
  logic [PRE_W:0]    filled_q, pre_words;
  logic [SEG_W-1:0]  seg_idx_q;
  logic              done_q, rise, dly_exp, dly_start, ready, off_last, seg_last;

  assign mode = acq_mode_e'(mode_i);

  acq_trig_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .trig_i(trig_i), .rise_o(rise)
  );

  acq_delay_timer #(.W(DLY_W)) i_dly (
    .clk_i (clk_i), .rst_ni(rst_ni), .start_i(dly_start), .len_i(delay_i), .exp_o(dly_exp)
  );

  acq_pre_depth #(.PRE_W(PRE_W), .PRE_MAX(PRE_MAX)) i_depth (
    .dual_i(dual_i), .pre_i(pre_i), .words_o(pre_words)
  );

  assign off_last  = (off_q == len_i - LEN_W'(1));
  assign off_nxt   = off_last ? '0 : off_q + LEN_W'(1);
  assign ready     = (filled_q >= pre_words);
  assign seg_last  = (SC_W'(seg_idx_q) + SC_W'(1)) >= SC_W'(seg_num_i);
  assign tail_len  = len_i - LEN_W'(pre_words);
  assign dly_start = (state_q == S_WAIT) && rise && (delay_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      seg_base_q  <= '0;
      trig_addr_q <= '0;
      off_q       <= '0;
      rem_q       <= '0;
      filled_q    <= '0;
      seg_idx_q   <= '0;
      done_q      <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (arm_i) begin
          done_q     <= 1'b0;
          seg_base_q <= base_i;
          off_q      <= '0;
          seg_idx_q  <= '0;
          filled_q   <= '0;
          state_q    <= (mode == MODE_PRE) ? S_RING : S_WAIT;
        end
        S_WAIT: if (rise) state_q <= (delay_i == '0) ? S_FILL : S_DLY;
        S_DLY:  if (dly_exp) state_q <= S_FILL;
        S_FILL: begin
          off_q <= off_nxt;
          if (off_last) begin
            if (mode == MODE_SEG) begin
              seg_base_q <= seg_base_q + len_i[ADDR_W-1:0];
              seg_idx_q  <= seg_idx_q + SEG_W'(1);
              if (seg_last) begin
                done_q  <= 1'b1;
                state_q <= S_IDLE;
              end else begin
                state_q <= S_WAIT;
              end
            end else begin
              done_q  <= 1'b1;
              state_q <= S_IDLE;
            end
          end
        end
        S_RING: begin
          off_q <= off_nxt;
          if (filled_q < pre_words) filled_q <= filled_q + 1'b1;
          if (rise && ready) begin
            trig_addr_q <= wr_addr_o;
            rem_q       <= tail_len;
            if (tail_len == '0) begin
              done_q  <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              state_q <= S_TAIL;
            end
          end
        end
        S_TAIL: begin
          off_q <= off_nxt;
          rem_q <= rem_q - LEN_W'(1);
          if (rem_q == LEN_W'(1)) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign wr_en_o     = (state_q == S_FILL) || (state_q == S_RING) || (state_q == S_TAIL);
  assign wr_addr_o   = seg_base_q + off_q[ADDR_W-1:0];
  assign wr_data_o   = sample_i;
  assign trig_addr_o = trig_addr_q;
  assign armed_o     = (state_q == S_WAIT) || ((state_q == S_RING) && ready);
  assign done_o      = done_q;

  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !arm_i) |=> done_o) else $error("done dropped"); // R9
  AST_ARM_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && arm_i) |=> !done_o) else $error("done not cleared"); // R9
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !wr_en_o) else $error("write after done"); // R2
  AST_IN_REGION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (off_q < len_i)) else $error("offset out of region"); // R4
  AST_PRE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_TAIL && $past(state_q) == S_RING) |-> ($past(filled_q) >= $past(pre_words)))
    else $error("trigger before history"); // R5
  AST_SEG_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == S_FILL && state_q != S_FILL && $past(mode) == MODE_SEG)
    |-> (seg_base_q == $past(seg_base_q) + $past(len_i[ADDR_W-1:0])))
    else $error("segment base step"); // R7
  AST_BUSY_DEAF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_FILL || state_q == S_DLY) |-> !armed_o) else $error("armed while busy"); // R8
endmodule

// File: tb/test_acq_trig_ctrl.sv
module test_acq_trig_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        arm_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic        dual_i = 1'b0;
  logic [26:0] base_i = '0;
  logic [27:0] len_i = 28'd1;
  logic [13:0] pre_i = '0;
  logic [16:0] delay_i = '0;
  logic [7:0]  seg_num_i = 8'd1;
  logic        trig_i = 1'b0;
  logic [15:0] sample_i;
  logic        wr_en_o, armed_o, done_o;
  logic [26:0] wr_addr_o, trig_addr_o;
  logic [15:0] wr_data_o;

  int unsigned tcnt = 0;
  int          nchk = 0;
  int          nfail = 0;
  int unsigned wd = 0;
  logic        fin = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) tcnt <= tcnt + 1;
  assign sample_i = tcnt[15:0];

  acq_trig_ctrl i_acq_trig_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .arm_i(arm_i), .mode_i(mode_i), .dual_i(dual_i),
    .base_i(base_i), .len_i(len_i), .pre_i(pre_i), .delay_i(delay_i),
    .seg_num_i(seg_num_i), .trig_i(trig_i), .sample_i(sample_i),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .trig_addr_o(trig_addr_o), .armed_o(armed_o), .done_o(done_o)
  );

  // write monitor
  logic [15:0] mem [0:1023];
  int          wcnt = 0, first_addr = 0, last_addr = 0, min_addr = 0, max_addr = 0;
  int unsigned first_t = 0;
  logic [15:0] first_data = '0, last_data = '0;
  logic        mon_clr = 1'b0;

  always @(negedge clk) begin
    if (mon_clr) begin
      wcnt = 0; min_addr = 32'h7fffffff; max_addr = 0;
    end else if (wr_en_o) begin
      mem[wr_addr_o[9:0]] = wr_data_o;
      if (wcnt == 0) begin
        first_addr = int'(wr_addr_o); first_data = wr_data_o; first_t = tcnt;
      end
      last_addr = int'(wr_addr_o); last_data = wr_data_o;
      if (int'(wr_addr_o) < min_addr) min_addr = int'(wr_addr_o);
      if (int'(wr_addr_o) > max_addr) max_addr = int'(wr_addr_o);
      wcnt = wcnt + 1;
    end
  end

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd == 190000 && !fin) begin
      $display("FAIL watchdog: actual %0d expected <190000 cycles", wd);
      $display("%0d/%0d checks passed", nchk - nfail, nchk + 1);
      $finish;
    end
  end

  function automatic longint m16(input longint v);
    return v & 64'hFFFF;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    @(negedge clk) mon_clr = 1'b1;
    @(negedge clk);
    @(negedge clk) mon_clr = 1'b0;
  endtask

  task automatic arm();
    @(negedge clk) arm_i = 1'b1;
    @(negedge clk) arm_i = 1'b0;
  endtask

  task automatic fire(output int unsigned s);
    @(negedge clk);
    trig_i = 1'b1;
    s = tcnt;
    repeat (3) @(negedge clk);
    trig_i = 1'b0;
  endtask

  task automatic wait_done(input int lim);
    for (int n = 0; n < lim && !done_o; n++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R9 done after reset", done_o, 0);
    chk("R2 no write after reset", wr_en_o, 0);
    chk("R8 not armed after reset", armed_o, 0);
  endtask

  task automatic t_post();
    int unsigned s;
    mode_i = 2'd0; base_i = 27'd100; len_i = 28'd20; delay_i = '0;
    clr_mon();
    fire(s);
    repeat (10) @(negedge clk);
    chk("R8 idle trigger writes", wcnt, 0);
    chk("R8 idle trigger done", done_o, 0);
    arm();
    chk("R8 armed in wait", armed_o, 1);
    fire(s);
    wait_done(100);
    chk("R2 word count", wcnt, 20);
    chk("R2 first addr", first_addr, 100);
    chk("R2 last addr", last_addr, 119);
    chk("R1 first word latency", m16(first_data), m16(longint'(s) + 3));
    chk("R2 last word", m16(last_data), m16(longint'(s) + 22));
    chk("R2 done", done_o, 1);
    repeat (20) @(negedge clk);
    chk("R9 done holds", done_o, 1);
  endtask

  task automatic t_delay(input int d);
    int unsigned s, x;
    mode_i = 2'd3; base_i = 27'd500; len_i = 28'd8; delay_i = 17'(d);
    clr_mon();
    arm();
    chk("R9 arm clears done", done_o, 0);
    fire(s);
    repeat (6) @(negedge clk);
    fire(x); // inside the delay window
    wait_done(d + 200);
    chk("R3 delay cycles", longint'(first_t) - longint'(s), 3 + d);
    chk("R3 delayed first word", m16(first_data), m16(longint'(s) + 3 + d));
    chk("R8 trigger during delay", wcnt, 8);
    chk("R2 done after delay fill", done_o, 1);
  endtask

  task automatic t_seg();
    int unsigned s [3];
    int unsigned x;
    mode_i = 2'd2; base_i = 27'd200; len_i = 28'd6; seg_num_i = 8'd3; delay_i = '0;
    clr_mon();
    arm();
    for (int k = 0; k < 3; k++) begin
      while (!armed_o && !done_o) @(negedge clk);
      fire(s[k]);
      if (k == 1) fire(x); // lands mid-fill
    end
    wait_done(100);
    chk("R7 total words", wcnt, 18);
    chk("R7 first addr", first_addr, 200);
    chk("R7 last addr", last_addr, 217);
    for (int k = 0; k < 3; k++) begin
      chk("R7 segment head", m16(mem[200 + 6 * k]), m16(longint'(s[k]) + 3));
      chk("R8 segment tail", m16(mem[205 + 6 * k]), m16(longint'(s[k]) + 8));
    end
    chk("R7 done", done_o, 1);
    seg_num_i = 8'd0; len_i = 28'd4;
    clr_mon();
    arm();
    fire(x);
    wait_done(50);
    chk("R7 zero count as one", wcnt, 4);
    chk("R7 zero count done", done_o, 1);
  endtask

  task automatic t_pre();
    int unsigned s, x;
    int ta, o;
    mode_i = 2'd1; base_i = 27'd300; len_i = 28'd40; pre_i = 14'd10; dual_i = 1'b0;
    clr_mon();
    arm();
    fire(x); // history not yet full
    repeat (20) @(negedge clk);
    chk("R5 early trigger dropped", done_o, 0);
    chk("R4 ring writing", wr_en_o, 1);
    repeat (40) @(negedge clk);
    fire(s);
    wait_done(100);
    ta = int'(trig_addr_o);
    chk("R5 trigger word", m16(mem[ta]), m16(longint'(s) + 2));
    o = ((ta - 300 - 9 + 40) % 40) + 300;
    chk("R5 oldest history word", m16(mem[o]), m16(longint'(s) + 2 - 9));
    chk("R5 tail length", m16(last_data), m16(longint'(s) + 2 + 30));
    chk("R4 wrap end addr", last_addr, ((ta - 300 + 30) % 40) + 300);
    chk("R4 lowest addr", min_addr, 300);
    chk("R4 highest addr", max_addr, 339);
    chk("R5 done", done_o, 1);
  endtask

  task automatic t_clamp(input logic dual, input int pre, input int exp_p);
    int unsigned s;
    int n;
    mode_i = 2'd1; base_i = '0; len_i = 28'd8300; pre_i = 14'(pre); dual_i = dual;
    arm();
    n = 0;
    while (!armed_o && n < 9000) begin
      n++;
      @(negedge clk);
    end
    chk("R6 history depth", n, exp_p);
    fire(s);
    wait_done(9000);
    chk("R6 capture completes", done_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_post();
    t_delay(1);
    t_delay(40);
    t_delay(65536);
    t_seg();
    t_pre();
    t_clamp(1'b0, 100, 100);
    t_clamp(1'b1, 100, 200);
    t_clamp(1'b1, 5000, 8192);
    t_clamp(1'b0, 10000, 8192);
    fin = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule